// File: doc/BRIEF.md
# Secondary Split Fetch Selector

This block chooses, once per clock, at most one warp whose divergent secondary split gets an instruction fetch into the upper half of that warp's instruction buffer. Warps are examined in round-robin order. The scan starts at the warp the primary fetch path served most recently and wraps around the warp count. A warp qualifies when it is still running, is not virtualized, has an empty upper buffer half, and offers a secondary split. That split's thread mask must also share no thread with the mask already bound to the lower buffer half, when the lower half is bound.

Each qualifying warp, in scan order, raises a lookup request to the instruction cache, addressed by its split PC. The cache answers hit or miss in the same cycle. A miss leaves nothing pending, and the scan moves on to the next qualifying warp. The first hit ends the scan. The selector then pulses a one-hot half-binding strobe for that warp and, on the next clock edge, loads a fetch record. The record carries the warp, half index 1, split PC, split id, split mask and fetch byte count. A perfect-cache input makes every lookup count as a hit. The record holds until the decode side clears it. While the record is full the selector does no work.

Top module: `sfs_sel`

## Requirements
- R1: No lookup request and no binding strobe are raised unless `part_en_i` and `reconv_mode_i` are both 1 and the fetch record is empty (`rec_valid_o` = 0).
- R2: A warp is never looked up when its done bit or virtualized bit is 1, its upper-half-empty bit is 0, or its secondary-split-available bit is 0.
- R3: A warp whose `half0_assigned_i` bit is 1 is skipped when its secondary mask ANDed with its lower-half mask is nonzero. When `half0_assigned_i` is 0, the lower-half mask has no effect.
- R4: The scan visits warp indices `last_warp_i`, `last_warp_i`+1, ... modulo NW. The first qualifying warp in that order that hits is selected.
- R5: `lookup_o` has bit w set for every qualifying warp up to and including the selected one in scan order. When none hits, it has a bit set for every qualifying warp. A miss leaves no state behind.
- R6: With `perfect_cache_i` = 1, every lookup counts as a hit, whatever `lookup_hit_i` says.
- R7: With offset = PC mod LINE_BYTES, the fetch byte count is FETCH_BYTES when offset + FETCH_BYTES <= LINE_BYTES, and LINE_BYTES - offset otherwise (defaults 16 and 64).
- R8: In the cycle of a hit, `assign_o` is one-hot on the selected warp. After the next rising edge, `rec_valid_o` = 1, `rec_half_o` = 1, and `rec_warp_o`, `rec_pc_o`, `rec_id_o` and `rec_mask_o` equal the selected warp's secondary split inputs.
- R9: A full record keeps its contents until a cycle with `rec_clear_i` = 1. After the edge that ends that cycle, `rec_valid_o` = 0.
- R10: After reset the record is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| part_en_i | input | 1 | Lane partitioning enabled |
| reconv_mode_i | input | 1 | Split-aware reconvergence mode |
| perfect_cache_i | input | 1 | Treat every lookup as a hit |
| last_warp_i | input | $clog2(NW) | Warp most recently fetched by the primary path; scan start |
| warp_done_i | input | NW | Per-warp finished flag |
| warp_virt_i | input | NW | Per-warp virtualized flag |
| half1_empty_i | input | NW | Per-warp upper buffer half empty |
| sec_avail_i | input | NW | Per-warp secondary split present |
| sec_pc_i | input | NW*PC_W | Per-warp secondary split PC (also the lookup address) |
| sec_id_i | input | NW*ID_W | Per-warp secondary split id |
| sec_mask_i | input | NW*MASK_W | Per-warp secondary split thread mask |
| half0_assigned_i | input | NW | Per-warp lower half bound to a split |
| half0_mask_i | input | NW*MASK_W | Per-warp lower half thread mask |
| lookup_hit_i | input | NW | Per-warp cache hit response for this cycle |
| rec_clear_i | input | 1 | Decode consumed the record |
| lookup_o | output | NW | Per-warp cache lookup request |
| assign_o | output | NW | One-hot strobe: bind upper half to the split |
| rec_valid_o | output | 1 | Fetch record full |
| rec_half_o | output | 1 | Record buffer half index |
| rec_warp_o | output | $clog2(NW) | Record warp index |
| rec_pc_o | output | PC_W | Record fetch PC |
| rec_bytes_o | output | $clog2(FETCH_BYTES+1) | Record fetch byte count |
| rec_id_o | output | ID_W | Record split id |
| rec_mask_o | output | MASK_W | Record split mask |

## Verification
The bench sweeps several hundred random warp states over every scan start position, along with every PC offset within a cache line. For each case it computes the expected lookup vector, the selected warp and the byte count by plain arithmetic. Several faults are aimed at directly:

- A selector that started one warp past `last_warp_i` would pick the wrong warp whenever two warps hit.
- A selector that stopped on the first qualifying warp would miss the hit behind a miss.
- An overlap filter that ignored the lower-half bound flag would drop warps whose masks clash only with an unbound half.
- A byte count that did not clip at the line end would report 16 for offsets above 48.

Hold-and-clear sequences show that a record that was overwritten, or that self-cleared, differs from the expected fields.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic {
    HALF_PRI = 1'b0,
    HALF_SEC = 1'b1
  } buf_half_e;

  typedef struct packed {
    logic [15:0] pc;
    logic [7:0]  mask;
  } unused_t;
endpackage

// File: rtl/sfs_cand.sv
module sfs_cand #(
  parameter int MASK_W = 8
) (
  input  logic              done_i,
  input  logic              virt_i,
  input  logic              h1_empty_i,
  input  logic              sec_avail_i,
  input  logic              h0_bound_i,
  input  logic [MASK_W-1:0] sec_mask_i,
  input  logic [MASK_W-1:0] h0_mask_i,
  output logic              cand_o
);
  logic clash;
  assign clash  = h0_bound_i && (|(sec_mask_i & h0_mask_i));
  assign cand_o = !done_i && !virt_i && h1_empty_i && sec_avail_i && !clash;
endmodule

// File: rtl/sfs_rr_pick.sv
module sfs_rr_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [N-1:0]     req_i,
  input  logic [N-1:0]     hit_i,
  output logic [N-1:0]     lookup_o,
  output logic [N-1:0]     grant_o,
  output logic             found_o,
  output logic [IDX_W-1:0] grant_idx_o
);
  // lookups stop after the first hit in rotated order
  always_comb begin
    lookup_o    = '0;
    grant_o     = '0;
    found_o     = 1'b0;
    grant_idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(start_i) + k) % N;
      if (!found_o && req_i[idx]) begin
        lookup_o[idx] = 1'b1;
        if (hit_i[idx]) begin
          found_o      = 1'b1;
          grant_o[idx] = 1'b1;
          grant_idx_o  = IDX_W'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/sfs_fetch_size.sv
module sfs_fetch_size #(
  parameter int PC_W        = 16,
  parameter int LINE_BYTES  = 64,
  parameter int FETCH_BYTES = 16,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int BYTES_W = $clog2(FETCH_BYTES + 1)
) (
  input  logic [PC_W-1:0]    pc_i,
  output logic [BYTES_W-1:0] bytes_o
);
  always_comb begin
    int off;
    off = int'(pc_i[OFF_W-1:0]);
    if (off + FETCH_BYTES > LINE_BYTES) bytes_o = BYTES_W'(LINE_BYTES - off);
    else                                bytes_o = BYTES_W'(FETCH_BYTES);
  end
endmodule

// File: rtl/sfs_sel.sv
module sfs_sel #(
  parameter int NW          = 4,
  parameter int PC_W        = 16,
  parameter int ID_W        = 3,
  parameter int MASK_W      = 8,
  parameter int LINE_BYTES  = 64,
  parameter int FETCH_BYTES = 16,
  localparam int WID_W   = (NW > 1) ? $clog2(NW) : 1,
  localparam int BYTES_W = $clog2(FETCH_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 part_en_i,
  input  logic                 reconv_mode_i,
  input  logic                 perfect_cache_i,
  input  logic [WID_W-1:0]     last_warp_i,
  input  logic [NW-1:0]        warp_done_i,
  input  logic [NW-1:0]        warp_virt_i,
  input  logic [NW-1:0]        half1_empty_i,
  input  logic [NW-1:0]        sec_avail_i,
  input  logic [NW*PC_W-1:0]   sec_pc_i,
  input  logic [NW*ID_W-1:0]   sec_id_i,
  input  logic [NW*MASK_W-1:0] sec_mask_i,
  input  logic [NW-1:0]        half0_assigned_i,
  input  logic [NW*MASK_W-1:0] half0_mask_i,
  input  logic [NW-1:0]        lookup_hit_i,
  input  logic                 rec_clear_i,
  output logic [NW-1:0]        lookup_o,
  output logic [NW-1:0]        assign_o,
  output logic                 rec_valid_o,
  output logic                 rec_half_o,
  output logic [WID_W-1:0]     rec_warp_o,
  output logic [PC_W-1:0]      rec_pc_o,
  output logic [BYTES_W-1:0]   rec_bytes_o,
  output logic [ID_W-1:0]      rec_id_o,
  output logic [MASK_W-1:0]    rec_mask_o
);
  import sfs_pkg::*;

  logic              active;
  logic [NW-1:0]     cand;
  logic [NW-1:0]     req;
  logic [NW-1:0]     hit_eff;
  logic              found;
  logic [WID_W-1:0]  gidx;
  logic [PC_W-1:0]   sel_pc;
  logic [ID_W-1:0]   sel_id;
  logic [MASK_W-1:0] sel_mask;
  logic [BYTES_W-1:0] sel_bytes;

  assign active  = part_en_i && reconv_mode_i && !rec_valid_o;
  assign req     = active ? cand : '0;
  assign hit_eff = perfect_cache_i ? '1 : lookup_hit_i;

  for (genvar w = 0; w < NW; w++) begin : g_cand
    sfs_cand #(.MASK_W(MASK_W)) u_cand (
      .done_i      (warp_done_i[w]),
      .virt_i      (warp_virt_i[w]),
      .h1_empty_i  (half1_empty_i[w]),
      .sec_avail_i (sec_avail_i[w]),
      .h0_bound_i  (half0_assigned_i[w]),
      .sec_mask_i  (sec_mask_i[w*MASK_W +: MASK_W]),
      .h0_mask_i   (half0_mask_i[w*MASK_W +: MASK_W]),
      .cand_o      (cand[w])
    );
  end

  sfs_rr_pick #(.N(NW)) u_pick (
    .start_i     (last_warp_i),
    .req_i       (req),
    .hit_i       (hit_eff),
    .lookup_o    (lookup_o),
    .grant_o     (assign_o),
    .found_o     (found),
    .grant_idx_o (gidx)
  );

  always_comb begin
    sel_pc   = '0;
    sel_id   = '0;
    sel_mask = '0;
    for (int w = 0; w < NW; w++) begin
      if (assign_o[w]) begin
        sel_pc   = sec_pc_i[w*PC_W +: PC_W];
        sel_id   = sec_id_i[w*ID_W +: ID_W];
        sel_mask = sec_mask_i[w*MASK_W +: MASK_W];
      end
    end
  end

  sfs_fetch_size #(
    .PC_W(PC_W), .LINE_BYTES(LINE_BYTES), .FETCH_BYTES(FETCH_BYTES)
  ) u_size (
    .pc_i    (sel_pc),
    .bytes_o (sel_bytes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_valid_o <= 1'b0;
      rec_half_o  <= HALF_PRI;
      rec_warp_o  <= '0;
      rec_pc_o    <= '0;
      rec_bytes_o <= '0;
      rec_id_o    <= '0;
      rec_mask_o  <= '0;
    end else if (found) begin
      rec_valid_o <= 1'b1;
      rec_half_o  <= HALF_SEC;
      rec_warp_o  <= gidx;
      rec_pc_o    <= sel_pc;
      rec_bytes_o <= sel_bytes;
      rec_id_o    <= sel_id;
      rec_mask_o  <= sel_mask;
    end else if (rec_clear_i) begin
      rec_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sfs_sel_chk.sv
module sfs_sel_chk #(
  parameter int NW          = 4,
  parameter int PC_W        = 16,
  parameter int FETCH_BYTES = 16,
  localparam int BYTES_W = $clog2(FETCH_BYTES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               part_en_i,
  input logic               reconv_mode_i,
  input logic               rec_clear_i,
  input logic [NW-1:0]      lookup_o,
  input logic [NW-1:0]      assign_o,
  input logic               rec_valid_o,
  input logic               rec_half_o,
  input logic [PC_W-1:0]    rec_pc_o,
  input logic [BYTES_W-1:0] rec_bytes_o
);
  p_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(part_en_i && reconv_mode_i) || rec_valid_o) |-> (lookup_o == '0 && assign_o == '0));

  p_assign_looked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (assign_o & ~lookup_o) == '0);

  p_size_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_bytes_o != '0 && int'(rec_bytes_o) <= FETCH_BYTES));

  p_onehot_assign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(assign_o));

  p_record_loads_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (assign_o != '0) |=> (rec_valid_o && rec_half_o));

  p_record_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_clear_i) |=> (rec_valid_o && $stable(rec_pc_o)));

  p_record_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_clear_i) |=> !rec_valid_o);
endmodule

bind sfs_sel sfs_sel_chk #(.NW(NW), .PC_W(PC_W), .FETCH_BYTES(FETCH_BYTES)) u_chk (.*);

// File: tb/sfs_sel_tb_top.sv
`timescale 1ns/1ps
module sfs_sel_tb_top;
  localparam int NW = 4, PC_W = 16, ID_W = 3, MASK_W = 8, LINE = 64, FB = 16;
  localparam int WID_W = 2, BYTES_W = 5;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic part_en = 0, reconv = 0, perfect = 0, clr = 0;
  logic [WID_W-1:0] last_w = '0;
  logic [NW-1:0] done = '0, virt = '0, h1e = '0, sav = '0, h0a = '0, hit = '0;
  logic [NW*PC_W-1:0] spc = '0;
  logic [NW*ID_W-1:0] sid = '0;
  logic [NW*MASK_W-1:0] smask = '0, h0mask = '0;
  logic [NW-1:0] lookup, asg;
  logic rv, rhalf;
  logic [WID_W-1:0] rwarp;
  logic [PC_W-1:0] rpc;
  logic [BYTES_W-1:0] rbytes;
  logic [ID_W-1:0] rid;
  logic [MASK_W-1:0] rmask;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  sfs_sel #(.NW(NW), .PC_W(PC_W), .ID_W(ID_W), .MASK_W(MASK_W),
            .LINE_BYTES(LINE), .FETCH_BYTES(FB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .part_en_i(part_en), .reconv_mode_i(reconv),
    .perfect_cache_i(perfect), .last_warp_i(last_w), .warp_done_i(done),
    .warp_virt_i(virt), .half1_empty_i(h1e), .sec_avail_i(sav), .sec_pc_i(spc),
    .sec_id_i(sid), .sec_mask_i(smask), .half0_assigned_i(h0a),
    .half0_mask_i(h0mask), .lookup_hit_i(hit), .rec_clear_i(clr),
    .lookup_o(lookup), .assign_o(asg), .rec_valid_o(rv), .rec_half_o(rhalf),
    .rec_warp_o(rwarp), .rec_pc_o(rpc), .rec_bytes_o(rbytes), .rec_id_o(rid),
    .rec_mask_o(rmask));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected results from the requirement text
  logic [NW-1:0] e_lk, e_gr;
  logic e_found;
  int e_w;
  task automatic model();
    e_lk = '0; e_gr = '0; e_found = 0; e_w = 0;
    if (part_en && reconv) begin
      for (int k = 0; k < NW; k++) begin
        int w;
        bit q;
        w = (int'(last_w) + k) % NW;
        q = !done[w] && !virt[w] && h1e[w] && sav[w] &&
            !(h0a[w] && ((smask[w*MASK_W +: MASK_W] & h0mask[w*MASK_W +: MASK_W]) != 0));
        if (!e_found && q) begin
          e_lk[w] = 1'b1;
          if (hit[w] || perfect) begin
            e_found = 1; e_gr[w] = 1'b1; e_w = w;
          end
        end
      end
    end
  endtask

  function automatic int exp_bytes(input logic [PC_W-1:0] pc);
    int off;
    off = int'(pc) % LINE;
    return (off + FB > LINE) ? LINE - off : FB;
  endfunction

  // called at a negedge with the record empty and inputs applied
  task automatic run_vec(input string tag);
    logic [PC_W-1:0] epc;
    #1;
    model();
    chk(lookup == e_lk, {tag, " R2 R3 R4 R5 R6 lookup"}, lookup, e_lk);
    chk(asg == e_gr, {tag, " R4 R8 assign"}, asg, e_gr);
    @(posedge clk); @(negedge clk);
    if (e_found) begin
      epc = spc[e_w*PC_W +: PC_W];
      chk(rv == 1'b1, "R8 valid", rv, 1);
      chk(rhalf == 1'b1, "R8 half", rhalf, 1);
      chk(int'(rwarp) == e_w, "R8 warp", rwarp, e_w);
      chk(rpc == epc, "R8 pc", rpc, epc);
      chk(rid == sid[e_w*ID_W +: ID_W], "R8 id", rid, sid[e_w*ID_W +: ID_W]);
      chk(rmask == smask[e_w*MASK_W +: MASK_W], "R8 mask", rmask, smask[e_w*MASK_W +: MASK_W]);
      chk(int'(rbytes) == exp_bytes(epc), "R7 bytes", rbytes, exp_bytes(epc));
      // record full: no further lookups, contents held (R1, R9)
      #1;
      chk(lookup == '0, "R1 full record blocks lookup", lookup, 0);
      @(posedge clk); @(negedge clk);
      chk(rv && rpc == epc, "R9 hold", rpc, epc);
      clr = 1'b1; part_en = 1'b0;
      @(posedge clk); @(negedge clk);
      clr = 1'b0;
      chk(rv == 1'b0, "R9 clear", rv, 0);
    end else begin
      chk(rv == 1'b0, "R1 R5 no record", rv, 0);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rv == 1'b0, "R10 reset record", rv, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rv == 1'b0 && lookup == '0, "R10 after reset", {rv, lookup}, 0);

    // directed: hit behind a miss, scan start at last warp (not one past)
    part_en = 1; reconv = 1; perfect = 0; last_w = 2'd1;
    done = '0; virt = '0; h1e = '1; sav = '1; h0a = '0; hit = 4'b0101;
    for (int w = 0; w < NW; w++) begin
      spc[w*PC_W +: PC_W] = PC_W'(16'h100 * (w + 1) + 4);
      sid[w*ID_W +: ID_W] = ID_W'(w + 1);
      smask[w*MASK_W +: MASK_W] = MASK_W'(8'h11 << w);
      h0mask[w*MASK_W +: MASK_W] = 8'hFF;
    end
    run_vec("dir-miss-skip");
    // R3: clash ignored when lower half unbound, applied when bound
    part_en = 1; last_w = 2'd0; hit = 4'b0001; h0a = 4'b0000;
    run_vec("dir-unbound");
    part_en = 1; h0a = 4'b0001; hit = 4'b0011;
    run_vec("dir-bound");
    // R1 gating off
    part_en = 1; reconv = 0; h0a = '0; hit = '1;
    run_vec("dir-gate");
    reconv = 1;

    // R7 sweep over every offset in a line, perfect cache (R6)
    for (int off = 0; off < LINE; off++) begin
      part_en = 1; perfect = 1; hit = '0; last_w = 2'(off % NW);
      done = '1; done[off % NW] = 1'b0; h0a = '0;
      spc[(off % NW)*PC_W +: PC_W] = PC_W'(($urandom_range(0, 255) * LINE) + off);
      run_vec("size-sweep");
    end

    // random sweep over warp states and scan starts
    for (int i = 0; i < 600; i++) begin
      part_en = ($urandom_range(0, 7) != 0);
      reconv  = ($urandom_range(0, 7) != 0);
      perfect = ($urandom_range(0, 7) == 0);
      last_w  = 2'(i % NW);
      for (int w = 0; w < NW; w++) begin
        done[w] = ($urandom_range(0, 3) == 0);
        virt[w] = ($urandom_range(0, 3) == 0);
        h1e[w]  = ($urandom_range(0, 3) != 0);
        sav[w]  = ($urandom_range(0, 3) != 0);
        h0a[w]  = $urandom_range(0, 1);
        hit[w]  = $urandom_range(0, 1);
        spc[w*PC_W +: PC_W] = PC_W'($urandom);
        sid[w*ID_W +: ID_W] = ID_W'($urandom);
        smask[w*MASK_W +: MASK_W] = MASK_W'($urandom & $urandom);
        h0mask[w*MASK_W +: MASK_W] = MASK_W'($urandom & $urandom);
      end
      run_vec("random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule